// File: doc/BRIEF.md
# March BIST with Supply-Rail Tuning Controller

This block tests an SRAM array in place and then steers its split supply rails to compensate for the cells that failed. It walks the whole array with a six-element March sequence through a synchronous single-port memory interface. Reads return data one cycle after the address is presented. Each mismatching bit of every read word is located at its physical row and column. The failure is classed only by the value the March element expected: an expected 0 is a ZERO failure and an expected 1 is a ONE failure. Whether the write or the read went wrong is not separated.

Every column carries a left and a right power-select bit, and every pair of adjacent rows shares a left and a right ground-select bit. A power-select of 1 moves that rail from the strong high supply to the weak low one. A ground-select of 1 moves that rail from the strong low ground to the weak raised one. A ZERO failure weakens the left power rail of its column and the right ground rail of its row pair. A ONE failure weakens the opposite pair of rails. Only the failing cell, at the crossing of the tuned column and row pair, therefore sees both of its rails moved.

The bank of select bits drives external header and footer switches. The block also reports a done flag, the total count of mismatching bits, and a count of intersection conflicts.

Top module: `supply_tune_bist`

## Requirements
- R1: After reset every select output is 0, meaning strong supply and strong ground; busy_o, done_o and both counters are 0.
- R2: A start_i pulse taken while the block is idle or done clears all selects and both counters and begins a new run. A start_i pulse while busy_o is high has no effect on that run.
- R3: One run issues exactly 10·N memory cycles for N = ROWS·COLS/WORD_W words: 5·N writes and 5·N reads. busy_o is high for 10·N+1 cycles, and done_o rises on the cycle busy_o falls. done_o stays high until the next accepted start.
- R4: A fault-free array ends the run with every select at 0 and both counters at 0.
- R5: A ZERO failure at row r, column c sets vdd_lo_l_o[c] and gnd_hi_r_o[r/2]. A cell stuck at 1 fails the three reads that expect 0, so it adds 3 to fail_bits_o.
- R6: A ONE failure at row r, column c sets vdd_lo_r_o[c] and gnd_hi_l_o[r/2]. A cell stuck at 0 fails the two reads that expect 1, so it adds 2 to fail_bits_o.
- R7: Word address a maps to row a / (COLS/WORD_W) and word index a % (COLS/WORD_W). Bit b of that word is column word_index·WORD_W + b.
- R8: All mismatching bits of one read word are applied in the same cycle, each to its own column.
- R9: A cell that fails both values gets all four of its rails weakened. conflict_o counts each mismatching bit whose opposite-polarity column and row-pair rails are already both weak while its own pair is not yet both weak. An inverting cell therefore yields conflict 1 and fail count 5.
- R10: Select bits only move toward the weak level during a run. fail_bits_o is the total number of mismatching bits seen and saturates at its maximum instead of wrapping.
- R11: Read data is compared exactly one cycle after its read address was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted when idle or done) |
| mem_addr_o | output | ADDR_W | Word address to the array |
| mem_we_o | output | 1 | Write enable; a cycle without it is a read |
| mem_wdata_o | output | WORD_W | Solid write pattern |
| mem_rdata_i | input | WORD_W | Read data, one cycle after the address |
| vdd_lo_l_o | output | COLS | Per-column left power rail weak select |
| vdd_lo_r_o | output | COLS | Per-column right power rail weak select |
| gnd_hi_l_o | output | ROWS/2 | Per-row-pair left ground rail weak select |
| gnd_hi_r_o | output | ROWS/2 | Per-row-pair right ground rail weak select |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, results valid |
| fail_bits_o | output | CNT_W | Total mismatching bits, saturating |
| conflict_o | output | CNT_W | Intersection conflict count |

## Verification
The bench runs the March sequence over a behavioural array in five patterns. A clean array checks the op count and that nothing is touched when nothing fails. A single stuck-at-1 cell in the second word of a row shows the ZERO rail pair and the column arithmetic. A stuck-at-0 cell in the last bit of the first word shows the ONE rail pair and that the previous run was cleared. A word with two failing bits at its extreme positions, combined with a failure in another word, shows that all bits are applied and that counts add up; a start pulse during this run shows it is ignored. An inverting cell separates the conflict counter from the plain fail count.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_DONE} state_e;

  localparam logic [2:0] LAST_ELEM = 3'd5;

  // element direction: 1 = ascending address
  function automatic logic elem_up(input logic [2:0] e);
    return !(e == 3'd3 || e == 3'd4);
  endfunction

  // single-op elements are the initial write and the final read
  function automatic logic elem_single(input logic [2:0] e);
    return (e == 3'd0) || (e == LAST_ELEM);
  endfunction

  // value expected on the read op of element e
  function automatic logic elem_rd_val(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  // value written on the write op of element e
  function automatic logic elem_wr_val(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction
endpackage

// File: rtl/stb_march_seq.sv
module stb_march_seq
  import stb_pkg::*;
#(
  parameter int unsigned N_WORDS = 256,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              wval_o,
  output logic              rd_issue_o,
  output logic              rd_exp_o,
  output logic              clr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(N_WORDS - 1);

  state_e            state_q;
  logic [2:0]        elem_q;
  logic              op_q;
  logic [ADDR_W-1:0] addr_q;

  logic is_read, last_op, last_addr, run;
  logic [2:0] elem_nx;

  assign run       = (state_q == ST_RUN);
  assign is_read   = (elem_q != 3'd0) && !op_q;
  assign last_op   = elem_single(elem_q) || op_q;
  assign last_addr = elem_up(elem_q) ? (addr_q == ADDR_LAST) : (addr_q == '0);
  assign elem_nx   = elem_q + 3'd1;
  assign clr_o     = start_i && (state_q == ST_IDLE || state_q == ST_DONE);

  assign addr_o     = addr_q;
  assign we_o       = run && !is_read;
  assign wval_o     = elem_wr_val(elem_q);
  assign rd_issue_o = run && is_read;
  assign rd_exp_o   = elem_rd_val(elem_q);
  assign busy_o     = run || (state_q == ST_DRAIN);
  assign done_o     = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      op_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          state_q <= ST_RUN;
          elem_q  <= '0;
          op_q    <= 1'b0;
          addr_q  <= '0;
        end
        ST_RUN: begin
          op_q <= !last_op;
          if (last_op) begin
            if (last_addr) begin
              if (elem_q == LAST_ELEM) state_q <= ST_DRAIN;
              else begin
                elem_q <= elem_nx;
                addr_q <= elem_up(elem_nx) ? '0 : ADDR_LAST;
              end
            end else begin
              addr_q <= elem_up(elem_q) ? addr_q + 1'b1 : addr_q - 1'b1;
            end
          end
        end
        ST_DRAIN: state_q <= ST_DONE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (addr_o <= ADDR_LAST));
  assert_start_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(clr_o)) |=> !$rose(state_q == ST_RUN) || $past(clr_o));
  assert_done_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_done_idle_port_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!we_o && !rd_issue_o));
endmodule

// File: rtl/stb_fail_eval.sv
module stb_fail_eval #(
  parameter int unsigned WORD_W = 128,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_issue_i,
  input  logic              rd_exp_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] mis_vec_o,
  output logic              mis_pol_o,
  output logic [ADDR_W-1:0] mis_addr_o
);
  logic              vld_q, exp_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      vld_q <= rd_issue_i;
      if (rd_issue_i) begin
        exp_q  <= rd_exp_i;
        addr_q <= rd_addr_i;
      end
    end
  end

  assign mis_vec_o  = vld_q ? (rdata_i ^ {WORD_W{exp_q}}) : '0;
  assign mis_pol_o  = exp_q;
  assign mis_addr_o = addr_q;

  assert_read_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mis_vec_o) |-> $past(rd_issue_i));
  assert_addr_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_issue_i |=> (mis_addr_o == $past(rd_addr_i)));
endmodule

// File: rtl/stb_rail_map.sv
module stb_rail_map #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned COLS   = 256,
  parameter int unsigned WORD_W = 128,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] mis_vec_i,
  input  logic              mis_pol_i,
  input  logic [ADDR_W-1:0] mis_addr_i,
  output logic [COLS-1:0]   vdd_l_o,
  output logic [COLS-1:0]   vdd_r_o,
  output logic [ROWS/2-1:0] gnd_l_o,
  output logic [ROWS/2-1:0] gnd_r_o,
  output logic [CNT_W-1:0]  fail_cnt_o,
  output logic [CNT_W-1:0]  conf_cnt_o
);
  localparam int unsigned WPR    = COLS / WORD_W;
  localparam int unsigned GROUPS = ROWS / 2;
  localparam int unsigned WIDX_W = (WPR > 1) ? $clog2(WPR) : 1;
  localparam int unsigned GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1;
  localparam int unsigned POP_W  = $clog2(WORD_W + 1);

  logic [COLS-1:0]   vdd_l_q, vdd_r_q, v0_hit, v1_hit;
  logic [GROUPS-1:0] gnd_l_q, gnd_r_q, g_hit;
  logic [CNT_W-1:0]  fail_q, conf_q;
  logic [ADDR_W-1:0] row_full;
  logic [WIDX_W-1:0] widx;
  logic [GRP_W-1:0]  grp;
  logic              any_mis;
  logic [POP_W-1:0]  fail_inc, conf_inc;

  assign row_full = mis_addr_i / ADDR_W'(WPR);
  assign widx     = WIDX_W'(mis_addr_i % ADDR_W'(WPR));
  assign grp      = GRP_W'(row_full >> 1);
  assign any_mis  = |mis_vec_i;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int unsigned WI = c / WORD_W;
    localparam int unsigned BI = c % WORD_W;
    logic hit;
    assign hit       = mis_vec_i[BI] && (widx == WIDX_W'(WI));
    assign v0_hit[c] = hit && !mis_pol_i;
    assign v1_hit[c] = hit && mis_pol_i;
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign g_hit[g] = any_mis && (grp == GRP_W'(g));
  end

  always_comb begin
    fail_inc = '0;
    conf_inc = '0;
    for (int b = 0; b < WORD_W; b++) begin
      int unsigned col;
      logic own_v, opp_v, own_g, opp_g;
      col   = int'(widx) * WORD_W + b;
      own_v = mis_pol_i ? vdd_r_q[col] : vdd_l_q[col];
      opp_v = mis_pol_i ? vdd_l_q[col] : vdd_r_q[col];
      own_g = mis_pol_i ? gnd_l_q[grp] : gnd_r_q[grp];
      opp_g = mis_pol_i ? gnd_r_q[grp] : gnd_l_q[grp];
      if (mis_vec_i[b]) begin
        fail_inc = fail_inc + 1'b1;
        if (opp_v && opp_g && !(own_v && own_g)) conf_inc = conf_inc + 1'b1;
      end
    end
  end

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [POP_W-1:0] d);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(d);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vdd_l_q <= '0;
      vdd_r_q <= '0;
      gnd_l_q <= '0;
      gnd_r_q <= '0;
      fail_q  <= '0;
      conf_q  <= '0;
    end else if (clr_i) begin
      vdd_l_q <= '0;
      vdd_r_q <= '0;
      gnd_l_q <= '0;
      gnd_r_q <= '0;
      fail_q  <= '0;
      conf_q  <= '0;
    end else begin
      vdd_l_q <= vdd_l_q | v0_hit;
      vdd_r_q <= vdd_r_q | v1_hit;
      gnd_r_q <= gnd_r_q | (mis_pol_i ? '0 : g_hit);
      gnd_l_q <= gnd_l_q | (mis_pol_i ? g_hit : '0);
      fail_q  <= sat_add(fail_q, fail_inc);
      conf_q  <= sat_add(conf_q, conf_inc);
    end
  end

  assign vdd_l_o    = vdd_l_q;
  assign vdd_r_o    = vdd_r_q;
  assign gnd_l_o    = gnd_l_q;
  assign gnd_r_o    = gnd_r_q;
  assign fail_cnt_o = fail_q;
  assign conf_cnt_o = conf_q;

  assert_sticky_vdd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (((vdd_l_q & $past(vdd_l_q)) == $past(vdd_l_q)) &&
                ((vdd_r_q & $past(vdd_r_q)) == $past(vdd_r_q))));
  assert_sticky_gnd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (((gnd_l_q & $past(gnd_l_q)) == $past(gnd_l_q)) &&
                ((gnd_r_q & $past(gnd_r_q)) == $past(gnd_r_q))));
  assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (fail_q >= $past(fail_q)));
  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (vdd_l_q == '0 && vdd_r_q == '0 && gnd_l_q == '0 &&
               gnd_r_q == '0 && fail_q == '0 && conf_q == '0));
  assert_conf_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conf_q <= fail_q);
endmodule

// File: rtl/supply_tune_bist.sv
module supply_tune_bist #(
  parameter int unsigned ROWS   = 128,
  parameter int unsigned COLS   = 256,
  parameter int unsigned WORD_W = 128,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned N_WORDS = ROWS * (COLS / WORD_W),
  localparam int unsigned ADDR_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [COLS-1:0]   vdd_lo_l_o,
  output logic [COLS-1:0]   vdd_lo_r_o,
  output logic [ROWS/2-1:0] gnd_hi_l_o,
  output logic [ROWS/2-1:0] gnd_hi_r_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  fail_bits_o,
  output logic [CNT_W-1:0]  conflict_o
);
  logic              wval, rd_issue, rd_exp, clr, mis_pol;
  logic [WORD_W-1:0] mis_vec;
  logic [ADDR_W-1:0] mis_addr;

  stb_march_seq #(.N_WORDS(N_WORDS), .ADDR_W(ADDR_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .addr_o(mem_addr_o), .we_o(mem_we_o), .wval_o(wval),
    .rd_issue_o(rd_issue), .rd_exp_o(rd_exp), .clr_o(clr),
    .busy_o, .done_o
  );

  assign mem_wdata_o = {WORD_W{wval}};

  stb_fail_eval #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_eval (
    .clk_i, .rst_ni,
    .rd_issue_i(rd_issue), .rd_exp_i(rd_exp), .rd_addr_i(mem_addr_o),
    .rdata_i(mem_rdata_i),
    .mis_vec_o(mis_vec), .mis_pol_o(mis_pol), .mis_addr_o(mis_addr)
  );

  stb_rail_map #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
                 .CNT_W(CNT_W)) u_map (
    .clk_i, .rst_ni, .clr_i(clr),
    .mis_vec_i(mis_vec), .mis_pol_i(mis_pol), .mis_addr_i(mis_addr),
    .vdd_l_o(vdd_lo_l_o), .vdd_r_o(vdd_lo_r_o),
    .gnd_l_o(gnd_hi_l_o), .gnd_r_o(gnd_hi_r_o),
    .fail_cnt_o(fail_bits_o), .conf_cnt_o(conflict_o)
  );

  assert_wdata_solid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == '0 || mem_wdata_o == '1));
endmodule

// File: tb/sim_supply_tune_bist.sv
module sim_supply_tune_bist;
  localparam int ROWS = 128, COLS = 256, W = 128, CNT_W = 16;
  localparam int WPR = COLS / W, N = ROWS * WPR, GROUPS = ROWS / 2, AW = 8;
  localparam int NF = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] addr;
  logic we;
  logic [W-1:0] wdata, rdata;
  logic [COLS-1:0] vl, vr;
  logic [GROUPS-1:0] gl, gr;
  logic busy, done;
  logic [CNT_W-1:0] fbits, conf;

  always #10 clk = ~clk;

  supply_tune_bist u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mem_addr_o(addr), .mem_we_o(we), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .vdd_lo_l_o(vl), .vdd_lo_r_o(vr), .gnd_hi_l_o(gl), .gnd_hi_r_o(gr),
    .busy_o(busy), .done_o(done), .fail_bits_o(fbits), .conflict_o(conf)
  );

  // behavioural array with injected faults: kind 0 none, 1 stuck-0, 2 stuck-1, 3 inverting
  logic [W-1:0] mem [N];
  int f_addr [NF], f_bit [NF], f_kind [NF];

  function automatic logic [W-1:0] faulty(input logic [W-1:0] d, input int a);
    logic [W-1:0] r = d;
    for (int i = 0; i < NF; i++)
      if (f_kind[i] != 0 && f_addr[i] == a)
        case (f_kind[i])
          1: r[f_bit[i]] = 1'b0;
          2: r[f_bit[i]] = 1'b1;
          default: r[f_bit[i]] = ~d[f_bit[i]];
        endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= faulty(mem[addr], int'(addr));
  end

  typedef struct {
    logic [COLS-1:0] vl, vr;
    logic [GROUPS-1:0] gl, gr;
    int bits, conf;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  int checks = 0, fails = 0, runs_done = 0;

  task automatic chk(input bit ok, input string req, input logic [COLS-1:0] act,
                     input logic [COLS-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: builds expected item from the requirements
  task automatic clear_faults();
    for (int i = 0; i < NF; i++) f_kind[i] = 0;
    cur.vl = '0; cur.vr = '0; cur.gl = '0; cur.gr = '0; cur.bits = 0; cur.conf = 0;
  endtask

  task automatic add_fault(input int idx, input int a, input int b, input int kind);
    int col, grp;
    f_addr[idx] = a; f_bit[idx] = b; f_kind[idx] = kind;
    col = (a % WPR) * W + b;        // R7
    grp = (a / WPR) / 2;
    if (kind == 2) begin cur.vl[col] = 1'b1; cur.gr[grp] = 1'b1; cur.bits += 3; end      // R5
    else if (kind == 1) begin cur.vr[col] = 1'b1; cur.gl[grp] = 1'b1; cur.bits += 2; end // R6
    else begin                                                                          // R9
      cur.vl[col] = 1'b1; cur.vr[col] = 1'b1; cur.gl[grp] = 1'b1; cur.gr[grp] = 1'b1;
      cur.bits += 5; cur.conf += 1;
    end
  endtask

  task automatic run_case(input bit poke_mid);
    int want;
    want = runs_done + 1;
    q.push_back(cur);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_mid) begin
      repeat (100) @(negedge clk);
      start = 1'b1;               // R2: ignored while busy
      @(negedge clk); start = 1'b0;
    end
    while (runs_done < want) @(negedge clk);
  endtask

  // monitor: pops expected items as runs complete
  int busy_cnt = 0, wr_cnt = 0;
  bit done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        busy_cnt++;
        if (we) wr_cnt++;
      end
      if (done && !done_prev && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(vl == e.vl, "R5/R8/R9/R4 vdd_lo_l", vl, e.vl);
        chk(vr == e.vr, "R6/R8/R9/R4 vdd_lo_r", vr, e.vr);
        chk(gl == e.gl, "R6/R9/R7 gnd_hi_l", COLS'(gl), COLS'(e.gl));
        chk(gr == e.gr, "R5/R9/R7 gnd_hi_r", COLS'(gr), COLS'(e.gr));
        chk(int'(fbits) == e.bits, "R10 fail_bits", COLS'(fbits), COLS'(e.bits));
        chk(int'(conf) == e.conf, "R9 conflict", COLS'(conf), COLS'(e.conf));
        chk(wr_cnt == 5 * N, "R3 write count", COLS'(wr_cnt), COLS'(5 * N));
        chk(busy_cnt == 10 * N + 1, "R3/R11 busy cycles", COLS'(busy_cnt), COLS'(10 * N + 1));
        busy_cnt = 0; wr_cnt = 0;
        runs_done++;
      end
      done_prev = done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vl == '0 && vr == '0, "R1 vdd selects", vl | vr, '0);
    chk(gl == '0 && gr == '0, "R1 gnd selects", COLS'(gl | gr), '0);
    chk(!busy && !done, "R1 busy/done", COLS'({busy, done}), '0);
    chk(fbits == '0 && conf == '0, "R1 counters", COLS'({fbits, conf}), '0);

    // R4: clean array
    clear_faults();
    run_case(1'b0);
    chk(done, "R3 done held", COLS'(done), COLS'(1));

    // R5 R7: stuck-1 in word 1 of row 2
    clear_faults();
    add_fault(0, 5, 7, 2);
    run_case(1'b0);

    // R6 R2: stuck-0 at last bit of word 0, row 100; prior run must be cleared
    clear_faults();
    add_fault(0, 200, W - 1, 1);
    run_case(1'b0);

    // R8: two bits of one word plus another word; mid-run start ignored (R2)
    clear_faults();
    add_fault(0, 9, 0, 2);
    add_fault(1, 9, W - 1, 2);
    add_fault(2, N - 1, 64, 1);
    run_case(1'b1);

    // R9: inverting cell at address 0 bit 0
    clear_faults();
    add_fault(0, 0, 0, 3);
    run_case(1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule